// File: doc/BRIEF.md
# Dual-Mode OS Interval Timer Channel

This block is one timer channel built around a counter of parameterised width (32 bits by default). It runs on the peripheral clock. Software controls it through a small register port: a single-cycle write strobe, and a read path that is purely combinational. The channel has two modes. In interval mode the counter loads the compare value and counts down to zero. On each zero it reloads itself, so a periodic interrupt repeats with no software action. In free-run mode the counter starts at zero and counts up through its whole range. Software can read it at any time as a timestamp, and an interrupt is raised when the count equals the compare value.

Software writes the compare value and the mode while the channel is stopped, then writes the start trigger. To stop the channel, software writes the stop trigger and polls the enable flag until it reads zero. The interrupt is a one-cycle pulse at the event that caused it. Reads have no side effects. All pins are plain control and status pins, and the block has no streaming interface, so there is no back-pressure to manage.

Top module: `tmr_channel`

## Requirements
- R1: After reset the compare value, the counter, the enable flag and the mode all read 0 (interval mode), and `irq` is low.
- R2: A write of a value with bit 0 set to the start trigger (offset 0x14) has an effect only while stopped. One cycle later the enable flag reads 1, and the counter holds the compare value in interval mode or 0 in free-run mode. A start write while the channel is running leaves counting undisturbed.
- R3: A write of a value with bit 0 set to the stop trigger (offset 0x18) clears the enable flag (offset 0x10, bit 0) one cycle later. The counter keeps its value for as long as the channel stays stopped.
- R4: A trigger write with bit 0 clear has no effect. Reads of offsets 0x14 and 0x18 return 0.
- R5: In interval mode the counter falls by one each cycle. When it reads 0, the next cycle reloads the compare value and pulses `irq`. The first pulse comes compare+1 cycles after the start edge and later pulses follow every compare+1 cycles, so a compare of 0 pulses on every cycle.
- R6: In free-run mode the counter rises by one each cycle and wraps from all ones to 0 without stopping.
- R7: In free-run mode, on the cycle after the count equals the compare value, `irq` pulses for one cycle. This also happens again after a wrap.
- R8: Mode is bit 1 of the control register (offset 0x20): 0 selects interval mode and 1 selects free-run mode. The other bits of that register read 0. While the channel runs, writes to the compare and control registers are ignored.
- R9: `irq` is never high while the channel is stopped. In free-run mode, and in interval mode with a nonzero compare value, no pulse lasts more than one cycle.
- R10: The compare value is at offset 0x00 (read/write) and the counter at offset 0x04 (read-only). Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | One-cycle event pulse |

## Verification
The inline properties are checked on every cycle. They cover the count step in each mode, including the zero reload and the wrap, the load that a start causes and the freeze that a stop causes, the lock on configuration while running, the single-cycle width of the pulse, and the zero read of the trigger offsets. Some behaviour can only be shown by the directed scenarios: the exact cycle on which the first and later interrupts appear for a given compare value, that a start or stop write with bit 0 clear leaves the channel as it was, the wrap observed at the register port on a narrow instance, and the value of every mapped and unmapped offset as read back.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BUS_W    = 32;
  localparam int OFS_CMP  = 'h00;
  localparam int OFS_CNT  = 'h04;
  localparam int OFS_STAT = 'h10;
  localparam int OFS_GO   = 'h14;
  localparam int OFS_HALT = 'h18;
  localparam int OFS_CTL  = 'h20;
  localparam int MODE_BIT = 1;
  localparam int TRIG_BIT = 0;

  typedef enum logic {
    MODE_INTERVAL = 1'b0,
    MODE_FREERUN  = 1'b1
  } tmr_mode_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              en_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CNT_W-1:0]  cmp_o,
  output tmr_mode_e         mode_o,
  output logic              start_o,
  output logic              stop_o
);
  localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(OFS_CMP);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_GO   = ADDR_W'(OFS_GO);
  localparam logic [ADDR_W-1:0] A_HALT = ADDR_W'(OFS_HALT);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_CTL);

  logic [CNT_W-1:0] cmp_q;
  tmr_mode_e        mode_q;
  logic             cfg_we;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;
  // configuration is frozen while the channel runs
  assign cfg_we  = wr_i && !en_i;
  assign start_o = wr_i && (addr_i == A_GO)   && wdata_i[TRIG_BIT];
  assign stop_o  = wr_i && (addr_i == A_HALT) && wdata_i[TRIG_BIT];
  assign cmp_o   = cmp_q;
  assign mode_o  = mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      mode_q <= MODE_INTERVAL;
    end else if (cfg_we) begin
      if (addr_i == A_CMP) cmp_q <= wdata_i[CNT_W-1:0];
      if (addr_i == A_CTL) mode_q <= tmr_mode_e'(wdata_i[MODE_BIT]);
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CMP:   rdata_o[CNT_W-1:0] = cmp_q;
      A_CNT:   rdata_o[CNT_W-1:0] = cnt_i;
      A_STAT:  rdata_o[0]         = en_i;
      A_CTL:   rdata_o[MODE_BIT]  = mode_q;
      default: rdata_o = '0;
    endcase
  end

  p_cfg_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> ($stable(cmp_q) && $stable(mode_q)));

  p_trig_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr_i == A_GO) || (addr_i == A_HALT)) |-> (rdata_o == '0));
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  tmr_mode_e        mode_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             en_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  logic             en_q;
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;
  logic             free;

  assign free  = (mode_i == MODE_FREERUN);
  assign en_o  = en_q;
  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (stop_i) begin
        en_q <= 1'b0;                       // counter holds
      end else if (start_i && !en_q) begin
        en_q  <= 1'b1;
        cnt_q <= free ? '0 : cmp_i;
      end else if (en_q) begin
        if (free) begin
          cnt_q <= cnt_q + CNT_W'(1);
          irq_q <= (cnt_q == cmp_i);
        end else if (cnt_q == '0) begin
          cnt_q <= cmp_i;
          irq_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !en_q && !stop_i) |=>
      (en_q && (cnt_q == (($past(mode_i) == MODE_FREERUN) ? '0 : $past(cmp_i)))));

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && en_q && free) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  p_stop_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!en_q && $stable(cnt_q)));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !start_i) |=> $stable(cnt_q));

  p_down_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !free && !stop_i && (cnt_q != '0)) |=>
      (cnt_q == $past(cnt_q) - CNT_W'(1)));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !free && !stop_i && (cnt_q == '0)) |=> ((cnt_q == $past(cmp_i)) && irq_q));

  p_up_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && free && !stop_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  p_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && free && !stop_i && (cnt_q == cmp_i)) |=> irq_q);

  p_irq_running_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(en_q && !stop_i));

  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && (free || (cmp_i != '0))) |=> !irq_q);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  logic             en;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp;
  tmr_mode_e        mode;
  logic             start;
  logic             stop;

  tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (reg_wr),
    .addr_i (reg_addr),
    .wdata_i(reg_wdata),
    .rdata_o(reg_rdata),
    .en_i   (en),
    .cnt_i  (cnt),
    .cmp_o  (cmp),
    .mode_o (mode),
    .start_o(start),
    .stop_o (stop)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start),
    .stop_i (stop),
    .mode_i (mode),
    .cmp_i  (cmp),
    .en_o   (en),
    .cnt_o  (cnt),
    .irq_o  (irq)
  );
endmodule

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb;
  localparam logic [7:0] A_CMP = 8'h00, A_CNT = 8'h04, A_STAT = 8'h10;
  localparam logic [7:0] A_GO = 8'h14, A_HALT = 8'h18, A_CTL = 8'h20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] rdata, rdata_s;
  logic        irq, irq_s;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tmr_channel u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata), .irq(irq)
  );

  // narrow counter so the wrap is reachable
  tmr_channel #(.CNT_W(8)) u_small (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_s), .irq(irq_s)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = rdata;
  endtask

  task automatic halt_and_poll();
    logic [31:0] v;
    bus_write(A_HALT, 32'h1);
    for (int i = 0; i < 8; i++) begin
      peek(A_STAT, v);
      if (v == 0) break;
      @(negedge clk);
    end
    check("R3", "enable after stop", v, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    peek(A_CMP, v);  check("R1", "compare", v, 0);
    peek(A_CNT, v);  check("R1", "counter", v, 0);
    peek(A_STAT, v); check("R1", "enable", v, 0);
    peek(A_CTL, v);  check("R1", "mode", v, 0);
    check("R1", "irq", {31'b0, irq}, 0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    bus_write(A_CTL, 32'hFF);
    peek(A_CTL, v);  check("R8", "control only mode bit", v, 32'h2);
    bus_write(A_CTL, 32'h0);
    peek(A_CTL, v);  check("R8", "control cleared", v, 32'h0);
    bus_write(A_CMP, 32'h1234_5678);
    peek(A_CMP, v);  check("R10", "compare readback", v, 32'h1234_5678);
    peek(8'h08, v);  check("R10", "unmapped offset", v, 0);
    peek(A_GO, v);   check("R4", "start trigger read", v, 0);
    peek(A_HALT, v); check("R4", "stop trigger read", v, 0);
  endtask

  task automatic t_interval();
    logic [31:0] v;
    bus_write(A_CMP, 32'd4);
    bus_write(A_CTL, 32'h0);
    bus_write(A_GO, 32'h1);
    peek(A_STAT, v); check("R2", "enable after start", v, 1);
    peek(A_CNT, v);  check("R2", "interval load", v, 4);
    for (int j = 1; j <= 15; j++) begin
      @(negedge clk);
      peek(A_CNT, v);
      check("R5", "down count", v, 32'(4 - (j % 5)));
      check("R5", "periodic irq", {31'b0, irq}, {31'b0, (j % 5) == 0});
    end
    halt_and_poll();
  endtask

  task automatic t_interval_zero();
    bus_write(A_CMP, 32'd0);
    bus_write(A_GO, 32'h1);
    for (int j = 1; j <= 4; j++) begin
      @(negedge clk); #1;
      check("R5", "compare 0 fires every cycle", {31'b0, irq}, 1);
    end
    halt_and_poll();
  endtask

  task automatic t_restart_ignored();
    logic [31:0] v;
    bus_write(A_CMP, 32'd4);
    bus_write(A_GO, 32'h1);
    @(negedge clk);
    bus_write(A_GO, 32'h1);
    peek(A_CNT, v); check("R2", "start while running ignored", v, 1);
    halt_and_poll();
  endtask

  task automatic t_freerun();
    logic [31:0] v, held;
    bus_write(A_CMP, 32'd6);
    bus_write(A_CTL, 32'h2);
    bus_write(A_GO, 32'h1);
    peek(A_CNT, v); check("R2", "free-run load", v, 0);
    for (int j = 1; j <= 10; j++) begin
      @(negedge clk);
      peek(A_CNT, v);
      check("R6", "up count", v, 32'(j));
      check("R7", "match irq", {31'b0, irq}, {31'b0, j == 7});
    end
    bus_write(A_CMP, 32'd100);
    bus_write(A_CTL, 32'h0);
    halt_and_poll();
    peek(A_CMP, v); check("R8", "compare locked while running", v, 6);
    peek(A_CTL, v); check("R8", "mode locked while running", v, 2);
    peek(A_CNT, held);
    for (int j = 0; j < 5; j++) begin
      @(negedge clk); #1;
      check("R9", "no irq while stopped", {31'b0, irq}, 0);
    end
    peek(A_CNT, v); check("R3", "counter holds while stopped", v, held);
  endtask

  task automatic t_trig_ignored();
    logic [31:0] v, held;
    peek(A_CNT, held);
    bus_write(A_GO, 32'h2);
    peek(A_STAT, v); check("R4", "start with bit0 clear", v, 0);
    @(negedge clk);
    peek(A_CNT, v);  check("R4", "counter untouched", v, held);
    bus_write(A_GO, 32'h1);
    bus_write(A_HALT, 32'hFE);
    peek(A_STAT, v); check("R4", "stop with bit0 clear", v, 1);
    halt_and_poll();
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    bus_write(A_CMP, 32'd3);
    bus_write(A_CTL, 32'h2);
    bus_write(A_GO, 32'h1);
    for (int j = 1; j <= 260; j++) begin
      @(negedge clk);
      reg_addr = A_CNT; #1;
      check("R7", "narrow match irq", {31'b0, irq_s}, {31'b0, (j == 4) || (j == 260)});
      if (j >= 255 && j <= 257)
        check("R6", "narrow wrap", rdata_s, 32'(j % 256));
      if (j == 260) begin
        v = rdata;
        check("R6", "wide counter no wrap", v, 32'd260);
      end
    end
    halt_and_poll();
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_interval();
    t_interval_zero();
    t_restart_ignored();
    t_freerun();
    t_trig_ignored();
    t_wrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule